// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block performs one timed access to an asynchronous NAND flash device. A host presents a request: a read/write flag, two host address bits that choose the latch-enable lines, and write data. The block accepts the request only while idle. It then steps through three phases, setup, strobe wait and hold, each measured in system clock cycles. It drives active-low chip enable, write enable and read enable, and drives the address-latch and command-latch enables from the request.

On a write, the shared data bus stays undriven for a programmed number of cycles from the start of the access. After that window, the block drives the write data through to the end of the hold phase. On a read, the block never drives the bus. It samples the bus on the last cycle of the strobe, just before read enable rises.

A one-cycle completion pulse ends every access and returns the captured read data. Each programmed duration is forced into its legal range before use. The data width is a parameter: 8 bits by default, or 16. The bus leaves the block as separate out, enable and in pins, and the tristate pad sits outside.

Top module: `nand_access_seq`

## Requirements
- R1: After a request is accepted, `nce` goes low in the next cycle. For exactly clamp(`cfg_setup`,1,255) cycles it stays low with `nwe` and `nre` both high, before a strobe asserts.
- R2: The strobe stays low for exactly clamp(`cfg_wait`,2,255) consecutive cycles. The strobe is `nwe` for a write (`req_write`=1) and `nre` for a read. The other strobe stays high for the whole access.
- R3: After the strobe rises, `nce` stays low for exactly clamp(`cfg_hold`,1,254) cycles with both strobes high. On a write, `dq_o` holds the write data during this phase.
- R4: On a write, `dq_oe` is low for the first min(clamp(`cfg_hiz`,1,255), setup+wait+hold) cycles of the access. It is then high until `nce` rises, with `dq_o` equal to the request's write data.
- R5: On a read, `dq_oe` never goes high. `rd_data` equals the value on `dq_i` during the last cycle in which `nre` is low.
- R6: During an access, `ale` equals `req_addr_hi[1]` (host address bit 17) and `cle` equals `req_addr_hi[0]` (host address bit 16). Both are 0 while idle.
- R7: `done` is high for exactly one cycle: the first cycle after the hold phase, with `nce` already high. `rd_data` is valid in that cycle.
- R8: `req_ready` is high only while no access is in progress. A `req_valid` held high during an access starts nothing; a new access begins only in a cycle in which `req_ready` is high.
- R9: Setting values below a phase's minimum behave as the minimum, and values above its maximum behave as the maximum. The ranges are setup 1..255, wait 2..255, hold 1..254 and high-Z 1..255.
- R10: Out of reset, `nce`, `nwe` and `nre` are high, `dq_oe`, `done`, `ale` and `cle` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr_hi | input | 2 | Host address bits 17 (bit 1) and 16 (bit 0) |
| req_wdata | input | DW | Data to write |
| cfg_setup | input | 8 | Setup phase length in cycles |
| cfg_wait | input | 8 | Strobe phase length in cycles |
| cfg_hold | input | 8 | Hold phase length in cycles |
| cfg_hiz | input | 8 | Write bus high-Z length in cycles |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Data captured on a read |
| nce | output | 1 | Chip enable, active low |
| nwe | output | 1 | Write enable, active low |
| nre | output | 1 | Read enable, active low |
| ale | output | 1 | Address latch enable |
| cle | output | 1 | Command latch enable |
| dq_o | output | DW | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | DW | Data bus input value |

## Verification
The bench uses settings of zero and of 255 on every phase. A sequencer without clamping would then produce a zero-length or wrapped phase, or a hold of 255, and the per-phase cycle counts would come out wrong. It also uses high-Z windows both shorter and longer than the whole access. An off-by-one window, or an enable that drops back before the end, shows up as a wrong undriven count or a broken drive interval.

Read data on `dq_i` changes every cycle. A capture one cycle early or late therefore returns a different value. Some accesses keep `req_valid` high throughout, which exposes a sequencer that restarts without waiting for idle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  localparam logic [7:0] SETUP_MIN = 8'd1;
  localparam logic [7:0] SETUP_MAX = 8'd255;
  localparam logic [7:0] WAIT_MIN  = 8'd2;
  localparam logic [7:0] WAIT_MAX  = 8'd255;
  localparam logic [7:0] HOLD_MIN  = 8'd1;
  localparam logic [7:0] HOLD_MAX  = 8'd254;
  localparam logic [7:0] HIZ_MIN   = 8'd1;
  localparam logic [7:0] HIZ_MAX   = 8'd255;

  // force a programmed duration into [lo, hi]
  function automatic logic [7:0] fit_range(input logic [7:0] v,
                                           input logic [7:0] lo,
                                           input logic [7:0] hi);
    logic [7:0] r;
    if (v < lo)      r = lo;
    else if (v > hi) r = hi;
    else             r = v;
    return r;
  endfunction

endpackage

// File: rtl/nand_phase_ctrl.sv
module nand_phase_ctrl
  import nand_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] setup_len,
  input  logic [7:0] wait_len,
  input  logic [7:0] hold_len,
  output seq_state_e state,
  output logic       phase_last
);

  logic [7:0] left_q;
  logic       in_phase;

  assign in_phase   = (state == ST_SETUP) || (state == ST_WAIT) || (state == ST_HOLD);
  assign phase_last = in_phase && (left_q == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      left_q <= 8'd0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SETUP;
          left_q <= setup_len - 8'd1;
        end
        ST_SETUP: if (phase_last) begin
          state  <= ST_WAIT;
          left_q <= wait_len - 8'd1;
        end else left_q <= left_q - 8'd1;
        ST_WAIT: if (phase_last) begin
          state  <= ST_HOLD;
          left_q <= hold_len - 8'd1;
        end else left_q <= left_q - 8'd1;
        ST_HOLD: if (phase_last) state <= ST_DONE;
                 else left_q <= left_q - 8'd1;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_phase |-> (left_q <= 8'd254));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));

  assert_setup_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && start |=> (state == ST_SETUP));

endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl #(
  parameter int DW = 8,
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  input  logic          wr,
  input  logic [7:0]    hiz_len,
  input  logic          capture,
  input  logic [DW-1:0] dq_i,
  output logic          oe,
  output logic [DW-1:0] rd_data
);

  localparam logic [EW-1:0] EL_MAX = {EW{1'b1}};

  logic [EW-1:0] elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      rd_data   <= '0;
    end else begin
      if (start)
        elapsed_q <= '0;
      else if (busy && elapsed_q != EL_MAX)
        elapsed_q <= elapsed_q + 1'b1;
      if (capture)
        rd_data <= dq_i;
    end
  end

  assign oe = busy && wr && (elapsed_q >= EW'(hiz_len));

  assert_oe_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> wr);

  assert_oe_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(oe) |-> oe);

endmodule

// File: rtl/nand_access_seq.sv
module nand_access_seq
  import nand_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_addr_hi,
  input  logic [DW-1:0] req_wdata,
  input  logic [7:0]    cfg_setup,
  input  logic [7:0]    cfg_wait,
  input  logic [7:0]    cfg_hold,
  input  logic [7:0]    cfg_hiz,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          nce,
  output logic          nwe,
  output logic          nre,
  output logic          ale,
  output logic          cle,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_i
);

  localparam int EW = 10;

  seq_state_e    state;
  logic          phase_last;
  logic          acc_start;
  logic          busy;
  logic          strobe_on;
  logic          rd_capture;
  logic [7:0]    setup_fit, wait_fit, hold_fit, hiz_fit;
  logic [7:0]    wait_q, hold_q, hiz_q;
  logic          wr_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] wdata_q;

  assign setup_fit = fit_range(cfg_setup, SETUP_MIN, SETUP_MAX);
  assign wait_fit  = fit_range(cfg_wait,  WAIT_MIN,  WAIT_MAX);
  assign hold_fit  = fit_range(cfg_hold,  HOLD_MIN,  HOLD_MAX);
  assign hiz_fit   = fit_range(cfg_hiz,   HIZ_MIN,   HIZ_MAX);

  assign req_ready  = (state == ST_IDLE);
  assign acc_start  = req_valid && req_ready;
  assign busy       = (state == ST_SETUP) || (state == ST_WAIT) || (state == ST_HOLD);
  assign strobe_on  = (state == ST_WAIT);
  assign rd_capture = strobe_on && phase_last && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= WAIT_MIN;
      hold_q  <= HOLD_MIN;
      hiz_q   <= HIZ_MIN;
      wr_q    <= 1'b0;
      sel_q   <= 2'b00;
      wdata_q <= '0;
    end else if (acc_start) begin
      wait_q  <= wait_fit;
      hold_q  <= hold_fit;
      hiz_q   <= hiz_fit;
      wr_q    <= req_write;
      sel_q   <= req_addr_hi;
      wdata_q <= req_wdata;
    end
  end

  nand_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (acc_start),
    .setup_len  (setup_fit),
    .wait_len   (wait_q),
    .hold_len   (hold_q),
    .state      (state),
    .phase_last (phase_last)
  );

  nand_bus_ctrl #(.DW(DW), .EW(EW)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (acc_start),
    .busy    (busy),
    .wr      (wr_q),
    .hiz_len (hiz_q),
    .capture (rd_capture),
    .dq_i    (dq_i),
    .oe      (dq_oe),
    .rd_data (rd_data)
  );

  assign nce  = !busy;
  assign nwe  = !(strobe_on && wr_q);
  assign nre  = !(strobe_on && !wr_q);
  assign ale  = busy && sel_q[1];
  assign cle  = busy && sel_q[0];
  assign dq_o = wdata_q;
  assign done = (state == ST_DONE);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nwe && !nre));

  assert_strobe_in_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nwe || !nre) |-> !nce);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nce |-> !req_ready);

  assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && !cle && nce));

  assert_drive_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe && $past(dq_oe) |-> $stable(dq_o));

  assert_done_ce_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> nce);

endmodule

// File: tb/sim_nand_access_seq.sv
module sim_nand_access_seq;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_addr_hi = 2'b00;
  logic [DW-1:0] req_wdata = '0;
  logic [7:0]    cfg_setup = 8'd1, cfg_wait = 8'd2, cfg_hold = 8'd1, cfg_hiz = 8'd1;
  logic          done;
  logic [DW-1:0] rd_data;
  logic          nce, nwe, nre, ale, cle, dq_oe;
  logic [DW-1:0] dq_o;
  logic [DW-1:0] dq_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  nand_access_seq #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr_hi(req_addr_hi), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
    .done(done), .rd_data(rd_data), .nce(nce), .nwe(nwe), .nre(nre),
    .ale(ale), .cle(cle), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  // expected phase length: bounded from both sides
  function automatic int bound(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      finish_run();
    end
  end

  task automatic run_access(input bit wr, input logic [1:0] sel, input logic [DW-1:0] wd,
                            input int s, input int w, input int h, input int z,
                            input bit keep_valid);
    int es, ew, eh, ez;
    int c_setup, c_wait, c_hold, c_hiz;
    int bad_other, bad_data, bad_sel, bad_ready, oe_gap, oe_rd;
    bit seen_strobe, seen_oe, fin;
    logic [DW-1:0] last_rd;
    es = bound(s, 1, 255); ew = bound(w, 2, 255); eh = bound(h, 1, 254);
    ez = bound(z, 1, 255);
    if (ez > es + ew + eh) ez = es + ew + eh;
    c_setup = 0; c_wait = 0; c_hold = 0; c_hiz = 0;
    bad_other = 0; bad_data = 0; bad_sel = 0; bad_ready = 0; oe_gap = 0; oe_rd = 0;
    seen_strobe = 0; seen_oe = 0; fin = 0; last_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr_hi = sel; req_wdata = wd;
    cfg_setup = 8'(s); cfg_wait = 8'(w); cfg_hold = 8'(h); cfg_hiz = 8'(z);
    @(posedge clk);
    while (!fin) begin
      @(negedge clk);
      if (!keep_valid) req_valid = 1'b0;
      // scramble settings: latched values must be used
      cfg_wait = 8'($urandom_range(0, 255)); cfg_hold = 8'($urandom_range(0, 255));
      cfg_hiz = 8'($urandom_range(0, 255));
      if (done) begin
        fin = 1;
        chk(nce == 1'b1, "R7 nce high with done", nce, 1);
        if (!wr) chk(rd_data == last_rd, "R5 read capture", rd_data, last_rd);
        req_valid = 1'b0;
      end else begin
        if (nce) bad_other++;
        if (req_ready) bad_ready++;
        if (ale != sel[1] || cle != sel[0]) bad_sel++;
        if (wr ? !nre : !nwe) bad_other++;
        if ((wr ? nwe : nre) == 1'b0) begin
          c_wait++; seen_strobe = 1;
        end else if (!seen_strobe) c_setup++;
        else c_hold++;
        if (dq_oe) begin
          seen_oe = 1;
          if (!wr) oe_rd++;
          if (dq_o != wd) bad_data++;
        end else begin
          if (seen_oe) oe_gap++;
          if (!seen_oe) c_hiz++;
        end
        dq_i = DW'($urandom);
        if (!nre) last_rd = dq_i;
      end
    end
    chk(c_setup == es, "R1 setup cycles", c_setup, es);
    chk(c_wait == ew, "R2 strobe cycles", c_wait, ew);
    chk(c_hold == eh, "R3 hold cycles", c_hold, eh);
    chk(bad_other == 0, "R2 other strobe / ce", bad_other, 0);
    chk(bad_sel == 0, "R6 ale/cle", bad_sel, 0);
    chk(bad_ready == 0, "R8 ready while busy", bad_ready, 0);
    if (wr) begin
      chk(c_hiz == ez, "R4 high-Z cycles", c_hiz, ez);
      chk(oe_gap == 0, "R4 drive gap", oe_gap, 0);
      chk(bad_data == 0, "R3 write data held", bad_data, 0);
    end else begin
      chk(oe_rd == 0, "R5 no drive on read", oe_rd, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(nce == 1'b1 && req_ready == 1'b1, "R8 no restart", nce, 1);
    chk(ale == 1'b0 && cle == 1'b0, "R6 idle lines", ale + cle, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(nce && nwe && nre, "R10 strobes high", {nce, nwe, nre}, 7);
    chk(!dq_oe && !done && !ale && !cle, "R10 outputs low", {dq_oe, done, ale, cle}, 0);
    chk(req_ready == 1'b1, "R10 ready held in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && nce == 1'b1, "R10 idle after reset", req_ready, 1);
    // directed corners, R9 clamping
    run_access(1'b1, 2'b10, 8'hA5, 0, 0, 0, 0, 1'b0);
    run_access(1'b0, 2'b01, 8'h00, 255, 255, 255, 255, 1'b0);
    run_access(1'b1, 2'b11, 8'h3C, 2, 3, 255, 200, 1'b1);
    run_access(1'b0, 2'b00, 8'h00, 1, 2, 1, 9, 1'b1);
    run_access(1'b1, 2'b01, 8'h7E, 5, 4, 3, 6, 1'b0);
    for (int k = 0; k < 24; k++) begin
      run_access(1'($urandom), 2'($urandom), DW'($urandom),
                 $urandom_range(0, 40), $urandom_range(0, 40),
                 $urandom_range(0, 40), $urandom_range(0, 90), 1'($urandom));
    end
    finish_run();
  end

endmodule